// File: doc/BRIEF.md
# Switch Control and Test Register File

This block is the memory-mapped control window of a multi-port switch. A host reaches it through a simple valid/ready register bus. Each access is either 4 bytes or 8 bytes wide, and all data is little-endian. The window holds the following registers:

- a 32-bit scratch register and a 64-bit scratch register, which read back doubled so that the host can prove a round trip;
- a DMA test address and a DMA test size;
- a control register whose clear bit wipes the test state;
- a read-only port count and a read-only 64-bit switch identifier;
- a port enable bitmap and a live link-status bitmap;
- four fixed-pattern signature words.

A host that can only issue 32-bit stores writes a 64-bit register in two steps. The low half goes into one holding word that all three writable 64-bit registers share. The high-half store merges with that holding word, commits the register and empties the holding word. When the enable bitmap changes, each port whose bit flipped receives a one-cycle enable or disable pulse. Ports whose bit stays the same receive nothing.

The bus side is a two-state machine:

- `ST_IDLE`: `req_ready` is high. An accepted write completes in the same cycle and stays in `ST_IDLE`. An accepted read takes the transition *read accept* to `ST_RESP`.
- `ST_RESP`: `rsp_valid` is high with the registered read data, and `req_ready` is low. The transition *response done* always returns to `ST_IDLE` after one cycle.

Top module: `swctl_regfile`

## Requirements
- R1: `req_wide`=1 selects an 8-byte access and `req_wide`=0 a 4-byte access. A 4-byte write uses only `req_wdata[31:0]`. A 4-byte read returns its value in `rsp_rdata[31:0]` with `rsp_rdata[63:32]` zero.
- R2: In `ST_IDLE`, `req_ready` is 1. An accepted read raises `rsp_valid` for exactly the one following cycle (`ST_RESP`), during which `req_ready` is 0. A write produces no response.
- R3: A 4-byte write to a low half (0x18 scratch64, 0x20 DMA address, 0x48 enable bitmap) only loads the single shared holding word. A 4-byte write to the matching high half (0x1C, 0x24, 0x4C) commits {wdata[31:0], holding word} to that register and clears the holding word to 0, whichever register loaded it.
- R4: An 8-byte write to 0x18, 0x20 or 0x48 commits all 64 bits at once and leaves the holding word unchanged.
- R5: The scratch register at 0x10 reads as twice its stored value, modulo 2^32. The 64-bit scratch register reads as twice its value, modulo 2^64: 8-byte at 0x18, or as low and high halves via 4-byte reads at 0x18 and 0x1C.
- R6: 4-byte reads of 0x00, 0x04, 0x08 and 0x0C return 0xDEADBABE. 8-byte reads of 0x00 and 0x08 return 0xDEADBABEDEADBABE. 8-byte reads of 0x04 and 0x0C return 0.
- R7: In the enable bitmap (0x48, halves 0x48/0x4C), port i sits at bit i+1. Bit 0 and bits above NPORTS are ignored on write and read as 0.
- R8: When the enable bitmap is committed, `port_en_pulse[i]` is high for the one cycle after the accepting edge only if port i goes from 0 to 1. `port_dis_pulse[i]` behaves the same way only if port i goes from 1 to 0. At all other times both are 0.
- R9: A 4-byte read of 0x38 returns NPORTS. The switch identifier reads as SWITCH_ID with an 8-byte read at 0x50, or as halves with 4-byte reads at 0x50 and 0x54.
- R10: A 4-byte write to 0x30 with bit 0 set clears the 32-bit scratch, 64-bit scratch, DMA address and DMA size registers. The enable bitmap and holding word keep their values. With bit 0 clear, the write has no effect.
- R11: The DMA address (written at 0x20/0x24, read 8-byte at 0x20 or as halves) and the DMA size (4-byte at 0x28) read back exactly as written.
- R12: The link-status bitmap (8-byte at 0x40, halves at 0x40/0x44) shows `link_up[i]` at bit i+1, sampled when the read is accepted. All other bits are 0.
- R13: Reads of any address or width not listed above return 0; this includes 8-byte reads of 0x10, 0x28 and 0x38. Writes of any address or width not listed above change nothing; this includes 8-byte writes to 0x10 and 4-byte writes to 0x50.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 64 | Read data |
| link_up | input | NPORTS | Per-port link state |
| port_en_pulse | output | NPORTS | One-cycle enable pulse per port |
| port_dis_pulse | output | NPORTS | One-cycle disable pulse per port |

## Verification
The hardest situation to reach from the ports is the shared holding word being loaded through one register's low half and consumed through a different register's high half. Reaching it needs an ordered sequence of three stores aimed at two different registers. The stimulus runs that crossover explicitly. It then issues a second high-half store and checks that the holding word came back as zero. It also places 8-byte writes and control-clear writes between a low-half store and its high-half store, to show that neither one disturbs the held value.

// File: rtl/swctl_pkg.sv
package swctl_pkg;

    typedef enum logic [0:0] {
        ST_IDLE,
        ST_RESP
    } bus_state_e;

    localparam logic [7:0] A_SIG0    = 8'h00;
    localparam logic [7:0] A_SIG1    = 8'h04;
    localparam logic [7:0] A_SIG2    = 8'h08;
    localparam logic [7:0] A_SIG3    = 8'h0C;
    localparam logic [7:0] A_SCR32   = 8'h10;
    localparam logic [7:0] A_SCR64L  = 8'h18;
    localparam logic [7:0] A_SCR64H  = 8'h1C;
    localparam logic [7:0] A_DMAL    = 8'h20;
    localparam logic [7:0] A_DMAH    = 8'h24;
    localparam logic [7:0] A_DMASZ   = 8'h28;
    localparam logic [7:0] A_CTRL    = 8'h30;
    localparam logic [7:0] A_PCNT    = 8'h38;
    localparam logic [7:0] A_LINKL   = 8'h40;
    localparam logic [7:0] A_LINKH   = 8'h44;
    localparam logic [7:0] A_ENL     = 8'h48;
    localparam logic [7:0] A_ENH     = 8'h4C;
    localparam logic [7:0] A_SWIDL   = 8'h50;
    localparam logic [7:0] A_SWIDH   = 8'h54;

    localparam logic [31:0] SIG_WORD = 32'hDEADBABE;

endpackage

// File: rtl/swctl_bus_fsm.sv
module swctl_bus_fsm
    import swctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    output logic req_ready,
    output logic rsp_valid,
    output logic wr_fire,
    output logic rd_fire
);

    bus_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid && !req_write) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_RESP: rsp_valid = 1'b1;
        endcase
    end

    assign wr_fire = req_valid && req_ready && req_write;
    assign rd_fire = req_valid && req_ready && !req_write;

    a_r2_resp_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fire |=> rsp_valid);
    a_r2_resp_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    a_r2_no_accept_in_resp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);
    a_r2_write_no_resp: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |=> !rsp_valid);

endmodule

// File: rtl/swctl_split_latch.sv
module swctl_split_latch #(
    parameter int unsigned HALF_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lo_wr,
    input  logic                hi_wr,
    input  logic [HALF_W-1:0]   wdata,
    output logic                commit,
    output logic [2*HALF_W-1:0] commit_val
);

    logic [HALF_W-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     hold_q <= '0;
        else if (hi_wr) hold_q <= '0;
        else if (lo_wr) hold_q <= wdata;
    end

    assign commit     = hi_wr;
    assign commit_val = {wdata, hold_q};

    a_r3_hold_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        hi_wr |=> hold_q == '0);
    a_r3_hold_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_wr && !hi_wr) |=> hold_q == $past(wdata));
    a_r4_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !(lo_wr || hi_wr) |=> $stable(hold_q));

endmodule

// File: rtl/swctl_port_map.sv
module swctl_port_map #(
    parameter int unsigned NPORTS = 4,
    parameter int unsigned BUS_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_wr,
    input  logic [NPORTS:1]   en_val,
    input  logic [NPORTS-1:0] link_in,
    output logic [BUS_W-1:0]  en_bitmap,
    output logic [BUS_W-1:0]  link_bitmap,
    output logic [NPORTS-1:0] en_pulse,
    output logic [NPORTS-1:0] dis_pulse
);

    logic [NPORTS-1:0] en_q;
    logic [NPORTS-1:0] en_pulse_q;
    logic [NPORTS-1:0] dis_pulse_q;

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q[p]        <= 1'b0;
                en_pulse_q[p]  <= 1'b0;
                dis_pulse_q[p] <= 1'b0;
            end else begin
                en_pulse_q[p]  <= en_wr && en_val[p+1] && !en_q[p];
                dis_pulse_q[p] <= en_wr && !en_val[p+1] && en_q[p];
                if (en_wr) en_q[p] <= en_val[p+1];
            end
        end
    end

    always_comb begin
        en_bitmap   = '0;
        link_bitmap = '0;
        en_bitmap[NPORTS:1]   = en_q;
        link_bitmap[NPORTS:1] = link_in;
    end

    assign en_pulse  = en_pulse_q;
    assign dis_pulse = dis_pulse_q;

    a_r8_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
        (en_pulse_q != '0) |-> (((en_pulse_q & ~en_q) == '0) && ((en_pulse_q & $past(en_q)) == '0)));
    a_r8_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_pulse_q != '0) |-> (((dis_pulse_q & en_q) == '0) && ((dis_pulse_q & ~$past(en_q)) == '0)));
    a_r8_quiet_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !en_wr |=> (en_pulse_q == '0 && dis_pulse_q == '0));

endmodule

// File: rtl/swctl_regfile.sv
module swctl_regfile
    import swctl_pkg::*;
#(
    parameter int unsigned NPORTS    = 4,
    parameter int unsigned ADDR_W    = 8,
    parameter logic [63:0] SWITCH_ID = 64'hA5C3_0F1E_2D3C_4B5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [63:0]       req_wdata,
    output logic              rsp_valid,
    output logic [63:0]       rsp_rdata,
    input  logic [NPORTS-1:0] link_up,
    output logic [NPORTS-1:0] port_en_pulse,
    output logic [NPORTS-1:0] port_dis_pulse
);

    localparam int unsigned DATA_W = 64;
    localparam int unsigned HALF_W = DATA_W / 2;

    logic              wr_fire, rd_fire;
    logic              w32, w64;
    logic              split_lo, split_hi, split_commit;
    logic [DATA_W-1:0] split_val;
    logic              en_wr;
    logic [DATA_W-1:0] en_src;
    logic [DATA_W-1:0] en_bitmap, link_bitmap;
    logic [HALF_W-1:0] scr32_q, dma_size_q;
    logic [DATA_W-1:0] scr64_q, dma_addr_q;
    logic [DATA_W-1:0] scr64_dbl;
    logic [HALF_W-1:0] scr32_dbl;
    logic [HALF_W-1:0] rd32;
    logic [DATA_W-1:0] rd_mux, rdata_q;
    logic              wr_hit;

    swctl_bus_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .wr_fire   (wr_fire),
        .rd_fire   (rd_fire)
    );

    assign w32 = wr_fire && !req_wide;
    assign w64 = wr_fire && req_wide;

    assign split_lo = w32 && (req_addr == ADDR_W'(A_SCR64L) ||
                              req_addr == ADDR_W'(A_DMAL)   ||
                              req_addr == ADDR_W'(A_ENL));
    assign split_hi = w32 && (req_addr == ADDR_W'(A_SCR64H) ||
                              req_addr == ADDR_W'(A_DMAH)   ||
                              req_addr == ADDR_W'(A_ENH));

    swctl_split_latch #(.HALF_W(HALF_W)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .lo_wr      (split_lo),
        .hi_wr      (split_hi),
        .wdata      (req_wdata[HALF_W-1:0]),
        .commit     (split_commit),
        .commit_val (split_val)
    );

    assign en_wr  = (w64 && req_addr == ADDR_W'(A_ENL)) ||
                    (split_commit && req_addr == ADDR_W'(A_ENH));
    assign en_src = req_wide ? req_wdata : split_val;

    swctl_port_map #(.NPORTS(NPORTS), .BUS_W(DATA_W)) u_ports (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_wr       (en_wr),
        .en_val      (en_src[NPORTS:1]),
        .link_in     (link_up),
        .en_bitmap   (en_bitmap),
        .link_bitmap (link_bitmap),
        .en_pulse    (port_en_pulse),
        .dis_pulse   (port_dis_pulse)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scr32_q    <= '0;
            scr64_q    <= '0;
            dma_addr_q <= '0;
            dma_size_q <= '0;
        end else if (w32) begin
            case (req_addr)
                ADDR_W'(A_SCR32): scr32_q    <= req_wdata[HALF_W-1:0];
                ADDR_W'(A_DMASZ): dma_size_q <= req_wdata[HALF_W-1:0];
                ADDR_W'(A_SCR64H): scr64_q   <= split_val;
                ADDR_W'(A_DMAH):  dma_addr_q <= split_val;
                ADDR_W'(A_CTRL): begin
                    if (req_wdata[0]) begin
                        scr32_q    <= '0;
                        scr64_q    <= '0;
                        dma_addr_q <= '0;
                        dma_size_q <= '0;
                    end
                end
                default: ;
            endcase
        end else if (w64) begin
            case (req_addr)
                ADDR_W'(A_SCR64L): scr64_q    <= req_wdata;
                ADDR_W'(A_DMAL):   dma_addr_q <= req_wdata;
                default: ;
            endcase
        end
    end

    assign scr32_dbl = scr32_q << 1;
    assign scr64_dbl = scr64_q << 1;

    always_comb begin
        rd32 = '0;
        case (req_addr)
            ADDR_W'(A_SIG0), ADDR_W'(A_SIG1),
            ADDR_W'(A_SIG2), ADDR_W'(A_SIG3): rd32 = SIG_WORD;
            ADDR_W'(A_SCR32):  rd32 = scr32_dbl;
            ADDR_W'(A_SCR64L): rd32 = scr64_dbl[HALF_W-1:0];
            ADDR_W'(A_SCR64H): rd32 = scr64_dbl[DATA_W-1:HALF_W];
            ADDR_W'(A_DMAL):   rd32 = dma_addr_q[HALF_W-1:0];
            ADDR_W'(A_DMAH):   rd32 = dma_addr_q[DATA_W-1:HALF_W];
            ADDR_W'(A_DMASZ):  rd32 = dma_size_q;
            ADDR_W'(A_PCNT):   rd32 = HALF_W'(NPORTS);
            ADDR_W'(A_LINKL):  rd32 = link_bitmap[HALF_W-1:0];
            ADDR_W'(A_LINKH):  rd32 = link_bitmap[DATA_W-1:HALF_W];
            ADDR_W'(A_ENL):    rd32 = en_bitmap[HALF_W-1:0];
            ADDR_W'(A_ENH):    rd32 = en_bitmap[DATA_W-1:HALF_W];
            ADDR_W'(A_SWIDL):  rd32 = SWITCH_ID[HALF_W-1:0];
            ADDR_W'(A_SWIDH):  rd32 = SWITCH_ID[DATA_W-1:HALF_W];
            default:           rd32 = '0;
        endcase
    end

    always_comb begin
        rd_mux = '0;
        if (req_wide) begin
            case (req_addr)
                ADDR_W'(A_SIG0), ADDR_W'(A_SIG2): rd_mux = {SIG_WORD, SIG_WORD};
                ADDR_W'(A_SCR64L): rd_mux = scr64_dbl;
                ADDR_W'(A_DMAL):   rd_mux = dma_addr_q;
                ADDR_W'(A_LINKL):  rd_mux = link_bitmap;
                ADDR_W'(A_ENL):    rd_mux = en_bitmap;
                ADDR_W'(A_SWIDL):  rd_mux = SWITCH_ID;
                default:           rd_mux = '0;
            endcase
        end else begin
            rd_mux = {{HALF_W{1'b0}}, rd32};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rdata_q <= '0;
        else if (rd_fire) rdata_q <= rd_mux;
    end

    assign rsp_rdata = rdata_q;

    always_comb begin
        wr_hit = 1'b0;
        if (req_wide) begin
            wr_hit = req_addr == ADDR_W'(A_SCR64L) || req_addr == ADDR_W'(A_DMAL) ||
                     req_addr == ADDR_W'(A_ENL);
        end else begin
            wr_hit = split_lo || split_hi || req_addr == ADDR_W'(A_SCR32) ||
                     req_addr == ADDR_W'(A_DMASZ) || req_addr == ADDR_W'(A_CTRL);
        end
    end

    a_r1_narrow_read_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && !req_wide) |=> rsp_rdata[DATA_W-1:HALF_W] == '0);
    a_r5_scratch32_doubled: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && !req_wide && req_addr == ADDR_W'(A_SCR32)) |=>
        rsp_rdata[HALF_W-1:0] == HALF_W'($past(scr32_q) * 2));
    a_r9_port_count: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && !req_wide && req_addr == ADDR_W'(A_PCNT)) |=>
        rsp_rdata == DATA_W'(NPORTS));
    a_r10_ctrl_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (w32 && req_addr == ADDR_W'(A_CTRL) && req_wdata[0]) |=>
        (scr32_q == '0 && scr64_q == '0 && dma_addr_q == '0 && dma_size_q == '0));
    a_r13_unmapped_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && !wr_hit) |=>
        ($stable(scr32_q) && $stable(scr64_q) && $stable(dma_addr_q) &&
         $stable(dma_size_q) && $stable(en_bitmap)));

endmodule

// File: tb/sim_swctl_regfile.sv
module sim_swctl_regfile;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam logic [63:0] SWID = 64'h0123_4567_89AB_CDEF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic          req_wide = 1'b0;
    logic [7:0]    req_addr = '0;
    logic [63:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [63:0]   rsp_rdata;
    logic [NP-1:0] link_up = '0;
    logic [NP-1:0] port_en_pulse;
    logic [NP-1:0] port_dis_pulse;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    swctl_regfile #(.NPORTS(NP), .ADDR_W(8), .SWITCH_ID(SWID)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_wide(req_wide), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .link_up(link_up), .port_en_pulse(port_en_pulse), .port_dis_pulse(port_dis_pulse)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic wide, input logic [7:0] a, input logic [63:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_wide = wide; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic wide, input logic [7:0] a, output logic [63:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_wide = wide; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        if (!rsp_valid || req_ready) begin
            checks++; errors++;
            $display("FAIL R2: actual valid=%0b ready=%0b expected valid=1 ready=0", rsp_valid, req_ready);
        end
        d = rsp_rdata;
    endtask

    task automatic rchk(input string req, input logic wide, input logic [7:0] a, input logic [63:0] exp);
        logic [63:0] d;
        rd(wide, a, d);
        chk(req, d, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] v, d;
        logic [NP-1:0] prev, cur;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 reset ready", {63'd0, req_ready}, 64'd1);
        chk("R2 reset valid", {63'd0, rsp_valid}, 64'd0);
        chk("R8 reset pulses", {56'd0, port_en_pulse, port_dis_pulse}, 64'd0);
        rchk("R5 reset scratch32", 1'b0, 8'h10, 64'd0);
        rchk("R5 reset scratch64", 1'b1, 8'h18, 64'd0);
        rchk("R7 reset enable", 1'b1, 8'h48, 64'd0);

        // R1 R5: 32-bit scratch sweep, doubled with wrap
        for (int i = 0; i < 16; i++) begin
            v = {32'hFFFF_FFFF, (32'(i) * 32'h1357_9BDF) ^ (32'h8000_0000 >> i)};
            wr(1'b0, 8'h10, v);
            rchk("R5 scratch32", 1'b0, 8'h10, {32'd0, v[30:0], 1'b0});
        end
        rchk("R1 narrow upper zero", 1'b0, 8'h10, {32'd0, v[30:0], 1'b0});

        // R3 R4 R5: 64-bit scratch, split and direct
        for (int i = 0; i < 8; i++) begin
            v = (64'(i) * 64'h9E37_79B9_7F4A_7C15) ^ (64'h8000_0000_0000_0000 >> (i * 5));
            if (i % 2 == 0) begin
                wr(1'b0, 8'h18, {32'hDEAD_0000, v[31:0]});
                wr(1'b0, 8'h1C, {32'hBEEF_0000, v[63:32]});
            end else begin
                wr(1'b1, 8'h18, v);
            end
            rchk("R5 scratch64 wide", 1'b1, 8'h18, v << 1);
            d = v << 1;
            rchk("R5 scratch64 low", 1'b0, 8'h18, {32'd0, d[31:0]});
            rchk("R5 scratch64 high", 1'b0, 8'h1C, {32'd0, d[63:32]});
        end

        // R3: shared holding word crossover and clearing
        wr(1'b0, 8'h18, 64'h0000_0000_AAAA_1111);
        rchk("R3 low-half only holds", 1'b1, 8'h18, v << 1);
        wr(1'b0, 8'h24, 64'h0000_0000_BBBB_2222);
        rchk("R3 crossover commit", 1'b1, 8'h20, 64'hBBBB_2222_AAAA_1111);
        wr(1'b0, 8'h1C, 64'h0000_0000_0000_0003);
        rchk("R3 holding cleared", 1'b1, 8'h18, 64'h0000_0006_0000_0000);

        // R4: 64-bit write between halves leaves holding word
        wr(1'b0, 8'h18, 64'h0000_0000_1234_5678);
        wr(1'b1, 8'h20, 64'hCAFE_F00D_0BAD_BEEF);
        wr(1'b0, 8'h1C, 64'h0000_0000_0000_0001);
        rchk("R4 holding kept", 1'b1, 8'h18, 64'h0000_0001_1234_5678 << 1);
        rchk("R11 dma addr wide", 1'b1, 8'h20, 64'hCAFE_F00D_0BAD_BEEF);
        rchk("R11 dma addr low", 1'b0, 8'h20, 64'h0BAD_BEEF);
        rchk("R11 dma addr high", 1'b0, 8'h24, 64'hCAFE_F00D);
        wr(1'b0, 8'h28, 64'h7777_7777_0000_1000);
        rchk("R11 dma size", 1'b0, 8'h28, 64'h0000_1000);

        // R6 signatures
        for (int i = 0; i < 4; i++) begin
            rchk("R6 sig32", 1'b0, 8'(i * 4), 64'h0000_0000_DEAD_BABE);
            rchk("R6 sig64", 1'b1, 8'(i * 4), (i % 2 == 0) ? 64'hDEAD_BABE_DEAD_BABE : 64'd0);
        end

        // R9
        rchk("R9 port count", 1'b0, 8'h38, 64'(NP));
        rchk("R9 switch id wide", 1'b1, 8'h50, SWID);
        rchk("R9 switch id low", 1'b0, 8'h50, {32'd0, SWID[31:0]});
        rchk("R9 switch id high", 1'b0, 8'h54, {32'd0, SWID[63:32]});

        // R7 R8: enable sweep, split and direct
        prev = '0;
        for (int k = 0; k < 32; k++) begin
            cur = NP'((k * 7 + 3) % 16);
            if (k % 2 == 0) begin
                wr(1'b1, 8'h48, {59'h7FF_FFFF_FFFF_FF00 >> 3, cur, 1'b1});
            end else begin
                wr(1'b0, 8'h48, {32'd0, 27'h7FF_FFFF, cur, 1'b1});
                chk("R8 no pulse on low half", {56'd0, port_en_pulse, port_dis_pulse}, 64'd0);
                wr(1'b0, 8'h4C, 64'hFFFF_FFFF_FFFF_FFFF);
            end
            chk("R8 enable pulses", {60'd0, port_en_pulse}, {60'd0, cur & ~prev});
            chk("R8 disable pulses", {60'd0, port_dis_pulse}, {60'd0, prev & ~cur});
            rchk("R7 enable readback", 1'b1, 8'h48, {59'd0, cur, 1'b0});
            prev = cur;
        end
        rchk("R7 enable high half", 1'b0, 8'h4C, 64'd0);

        // R12 link sweep
        for (int l = 0; l < 16; l++) begin
            @(negedge clk);
            link_up = NP'(l);
            rchk("R12 link wide", 1'b1, 8'h40, {59'd0, NP'(l), 1'b0});
            rchk("R12 link low", 1'b0, 8'h40, {59'd0, NP'(l), 1'b0});
            rchk("R12 link high", 1'b0, 8'h44, 64'd0);
        end

        // R10 control
        wr(1'b0, 8'h10, 64'h55);
        wr(1'b0, 8'h30, 64'hFFFF_FFFF_FFFF_FFFE);
        rchk("R10 bit0 clear no effect", 1'b0, 8'h10, 64'hAA);
        wr(1'b0, 8'h18, 64'h0000_0000_0000_4321);
        wr(1'b0, 8'h30, 64'h1);
        rchk("R10 scratch32 cleared", 1'b0, 8'h10, 64'd0);
        rchk("R10 scratch64 cleared", 1'b1, 8'h18, 64'd0);
        rchk("R10 dma addr cleared", 1'b1, 8'h20, 64'd0);
        rchk("R10 dma size cleared", 1'b0, 8'h28, 64'd0);
        rchk("R10 enable kept", 1'b1, 8'h48, {59'd0, prev, 1'b0});
        wr(1'b0, 8'h1C, 64'h2);
        rchk("R10 holding kept", 1'b1, 8'h18, 64'h0000_0002_0000_4321 << 1);

        // R13 unmapped
        wr(1'b0, 8'h10, 64'h100);
        wr(1'b1, 8'h10, 64'hFFFF_FFFF_FFFF_FFFF);
        rchk("R13 wide write to scratch32 ignored", 1'b0, 8'h10, 64'h200);
        wr(1'b0, 8'h50, 64'h0);
        rchk("R13 switch id not writable", 1'b1, 8'h50, SWID);
        wr(1'b0, 8'h60, 64'hFFFF_FFFF);
        wr(1'b1, 8'h28, 64'hFFFF_FFFF_FFFF_FFFF);
        rchk("R13 dma size untouched", 1'b0, 8'h28, 64'd0);
        rchk("R13 scratch32 untouched", 1'b0, 8'h10, 64'h200);
        rchk("R13 unmapped read", 1'b0, 8'h60, 64'd0);
        rchk("R13 misaligned read", 1'b0, 8'h12, 64'd0);
        rchk("R13 wide read of scratch32", 1'b1, 8'h10, 64'd0);
        rchk("R13 wide read of port count", 1'b1, 8'h38, 64'd0);
        rchk("R13 wide read of dma size", 1'b1, 8'h28, 64'd0);

        @(negedge clk);
        chk("R2 idle after response", {63'd0, req_ready}, 64'd1);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule